// File: doc/BRIEF.md
# 16-bit ALU with Inverted-Operand Logic

This block is the arithmetic and logic unit of a small 16-bit processor datapath. Each cycle it takes two register operands and an operation code, and it drives a 16-bit result combinationally. It also holds a 4-bit status register that records carry, signed overflow, negative and zero. The carry bit of that register is the carry-in for the add-with-carry and subtract-with-borrow operations. Wider arithmetic is built by running ADD on the lowest word and then ADDC on each higher word, one word per cycle.

The logic group has inverted-B forms alongside the plain ones. The shift group has one-bit shifts and rotates through carry, plus a barrel rotate left of 0 to 15 bits. An immediate mode replaces operand B with a zero-extended 8-bit constant. The status register updates only in cycles where the caller marks the operation valid.

Top module: `inv_logic_alu`

## Requirements
- R1: While rst_ni is low, flags_o is 0000.
- R2: ADD gives a+b. SUB gives a+~b+1, and its carry means no borrow. Carry is the unsigned carry-out of the 16-bit sum. Overflow is set when the signed result falls outside -32768..32767.
- R3: ADDC gives a+b+C and SUBC gives a+~b+C, where C is the stored carry flag. Chaining ADD with ADDC over 2 or 4 words gives the exact 32-bit or 64-bit sum.
- R4: The logic codes compute a op b for XOR(4), OR(6) and AND(8), and a op ~b for XNOR(5), ORN(7) and ANDN(9). Each of them clears carry and overflow.
- R5: When use_imm_i is 1, operand B is {8'h00, imm_i} for every operation.
- R6: SHL(10) and ASHL(14) shift B left by one bit with a zero fill. SHR(11) shifts B right by one bit with a zero fill. ASHR(15) shifts B right and keeps bit 15. In all four, carry takes the bit shifted out and overflow is 0.
- R7: ROLC(12) gives {b[14:0], C} with carry taken from b[15]. RORC(13) gives {C, b[15:1]} with carry taken from b[0]. Overflow is 0.
- R8: ROT(16) rotates A left by b[3:0] bits. The upper bits of B are ignored. Carry and overflow are cleared.
- R9: INV(17) gives ~b and clears carry and overflow.
- R10: flags_o is {C, V, N, Z} in bits 3..0. N is result bit 15 and Z is set for a zero result. The flags load on a clock edge only when valid_i is 1, and they hold otherwise.
- R11: Opcodes 18 to 31 give result 0 with carry and overflow cleared.
- R12: The arithmetic codes are ADD(0), SUB(1), ADDC(2) and SUBC(3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation valid; enables the flag update |
| op_i | input | 5 | Operation code |
| a_i | input | 16 | Operand A |
| b_i | input | 16 | Operand B |
| imm_i | input | 8 | Immediate constant |
| use_imm_i | input | 1 | Use the immediate as operand B |
| result_o | output | 16 | Combinational result |
| flags_o | output | 4 | Stored flags {C,V,N,Z} |

## Verification
The hardest cases to reach are those that depend on the stored carry: ADDC, SUBC, ROLC and RORC behave differently with C at 0 and at 1. The carry in turn depends on whatever valid operation came before. The bench follows the flag register in its own model through every valid and non-valid cycle. Random sequences therefore reach both carry states naturally. Directed chains set the carry on purpose with an all-ones add, then run multi-word ADD/ADDC sums for 32 and 64 bits and compare the result to the full-width sum.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,  OP_SUB  = 5'd1,  OP_ADDC = 5'd2,  OP_SUBC = 5'd3,
    OP_XOR  = 5'd4,  OP_XNOR = 5'd5,  OP_OR   = 5'd6,  OP_ORN  = 5'd7,
    OP_AND  = 5'd8,  OP_ANDN = 5'd9,  OP_SHL  = 5'd10, OP_SHR  = 5'd11,
    OP_ROLC = 5'd12, OP_RORC = 5'd13, OP_ASHL = 5'd14, OP_ASHR = 5'd15,
    OP_ROT  = 5'd16, OP_INV  = 5'd17
  } alu_op_e;

  localparam int unsigned FLAG_C = 3;
  localparam int unsigned FLAG_V = 2;
  localparam int unsigned FLAG_N = 1;
  localparam int unsigned FLAG_Z = 0;
  localparam int unsigned FLAG_W = 4;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         cin_i,
  output logic [W-1:0] res_o,
  output logic         cout_o,
  output logic         ovf_o
);
  logic [W-1:0] b_op;

  assign b_op = sub_i ? ~b_i : b_i;
  assign {cout_o, res_o} = {1'b0, a_i} + {1'b0, b_op} + {{W{1'b0}}, cin_i};
  // signed overflow: like-signed inputs, result sign differs
  assign ovf_o = (a_i[W-1] == b_op[W-1]) && (res_o[W-1] != a_i[W-1]);
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o
);
  logic [W-1:0] b_n;

  assign b_n = ~b_i;

  always_comb begin
    case (op_i)
      OP_XOR:  res_o = a_i ^ b_i;
      OP_XNOR: res_o = a_i ^ b_n;
      OP_OR:   res_o = a_i | b_i;
      OP_ORN:  res_o = a_i | b_n;
      OP_AND:  res_o = a_i & b_i;
      OP_ANDN: res_o = a_i & b_n;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/alu_shift.sv
module alu_shift
  import alu_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] res_o,
  output logic         cout_o
);
  localparam int unsigned SH_W = $clog2(W);

  logic [W-1:0] stage [SH_W+1];
  logic [W-1:0] rot_res;

  assign stage[0] = a_i;

  // log-depth left rotator, amount from b_i[SH_W-1:0]
  for (genvar s = 0; s < SH_W; s++) begin : g_rot
    localparam int unsigned K = 1 << s;
    assign stage[s+1] = b_i[s] ? {stage[s][W-1-K:0], stage[s][W-1:W-K]} : stage[s];
  end
  assign rot_res = stage[SH_W];

  always_comb begin
    res_o  = '0;
    cout_o = 1'b0;
    case (op_i)
      OP_SHL, OP_ASHL: begin res_o = {b_i[W-2:0], 1'b0};     cout_o = b_i[W-1]; end
      OP_SHR:          begin res_o = {1'b0, b_i[W-1:1]};     cout_o = b_i[0];   end
      OP_ASHR:         begin res_o = {b_i[W-1], b_i[W-1:1]}; cout_o = b_i[0];   end
      OP_ROLC:         begin res_o = {b_i[W-2:0], cin_i};    cout_o = b_i[W-1]; end
      OP_RORC:         begin res_o = {cin_i, b_i[W-1:1]};    cout_o = b_i[0];   end
      OP_ROT:          res_o = rot_res;
      default: ;
    endcase
  end
endmodule

// File: rtl/inv_logic_alu.sv
module inv_logic_alu
  import alu_pkg::*;
#(
  parameter int unsigned W     = 16,
  parameter int unsigned IMM_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [4:0]        op_i,
  input  logic [W-1:0]      a_i,
  input  logic [W-1:0]      b_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              use_imm_i,
  output logic [W-1:0]      result_o,
  output logic [FLAG_W-1:0] flags_o
);
  alu_op_e           op;
  logic [W-1:0]      b_eff;
  logic [FLAG_W-1:0] flags_q, flags_d;
  logic              c_q;

  logic [W-1:0] as_res, lg_res, sh_res;
  logic         as_c, as_v, sh_c, as_sub, as_cin;
  logic         c_d, v_d;

  assign op    = alu_op_e'(op_i);
  assign b_eff = use_imm_i ? {{(W-IMM_W){1'b0}}, imm_i} : b_i;
  assign c_q   = flags_q[FLAG_C];

  assign as_sub = (op == OP_SUB) || (op == OP_SUBC);
  assign as_cin = ((op == OP_ADDC) || (op == OP_SUBC)) ? c_q : (op == OP_SUB);

  alu_addsub #(.W(W)) u_addsub (
    .a_i(a_i), .b_i(b_eff), .sub_i(as_sub), .cin_i(as_cin),
    .res_o(as_res), .cout_o(as_c), .ovf_o(as_v)
  );

  alu_logic #(.W(W)) u_logic (
    .op_i(op), .a_i(a_i), .b_i(b_eff), .res_o(lg_res)
  );

  alu_shift #(.W(W)) u_shift (
    .op_i(op), .a_i(a_i), .b_i(b_eff), .cin_i(c_q),
    .res_o(sh_res), .cout_o(sh_c)
  );

  always_comb begin
    result_o = '0;
    c_d      = 1'b0;
    v_d      = 1'b0;
    case (op)
      OP_ADD, OP_SUB, OP_ADDC, OP_SUBC: begin
        result_o = as_res;
        c_d      = as_c;
        v_d      = as_v;
      end
      OP_XOR, OP_XNOR, OP_OR, OP_ORN, OP_AND, OP_ANDN: result_o = lg_res;
      OP_SHL, OP_SHR, OP_ROLC, OP_RORC, OP_ASHL, OP_ASHR, OP_ROT: begin
        result_o = sh_res;
        c_d      = sh_c;
      end
      OP_INV:  result_o = ~b_eff;
      default: ;
    endcase
  end

  always_comb begin
    flags_d         = '0;
    flags_d[FLAG_C] = c_d;
    flags_d[FLAG_V] = v_d;
    flags_d[FLAG_N] = result_o[W-1];
    flags_d[FLAG_Z] = (result_o == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flags_q <= '0;
    else if (valid_i) flags_q <= flags_d;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/alu_checks.sv
module alu_checks
  import alu_pkg::*;
#(
  parameter int unsigned W     = 16,
  parameter int unsigned IMM_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [4:0]        op_i,
  input logic [W-1:0]      a_i,
  input logic [W-1:0]      b_i,
  input logic [IMM_W-1:0]  imm_i,
  input logic              use_imm_i,
  input logic [W-1:0]      result_o,
  input logic [FLAG_W-1:0] flags_o
);
  a_r1_reset_clear: assert property (@(posedge clk_i) !rst_ni |=> flags_o == '0 || !rst_ni);

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(flags_o));

  a_r10_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> flags_o[FLAG_Z] == ($past(result_o) == '0));

  a_r10_neg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> flags_o[FLAG_N] == $past(result_o[W-1]));

  a_r4_logic_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i >= 5'd4 && op_i <= 5'd9 |=> !flags_o[FLAG_C] && !flags_o[FLAG_V]);

  a_r3_addc_zero_ops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_ADDC && !use_imm_i && a_i == '0 && b_i == '0
      |-> result_o == {{(W-1){1'b0}}, flags_o[FLAG_C]});

  a_r6_ashr_msb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_ASHR |-> result_o[W-1] == (use_imm_i ? 1'b0 : b_i[W-1]));

  a_r6_shl_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_SHL && !use_imm_i |=> flags_o[FLAG_C] == $past(b_i[W-1]));

  a_r5_imm_or: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_OR && use_imm_i
      |-> result_o == (a_i | {{(W-IMM_W){1'b0}}, imm_i}));

  a_r11_undef: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i > 5'd17 |-> result_o == '0);
endmodule

bind inv_logic_alu alu_checks #(.W(W), .IMM_W(IMM_W)) u_alu_checks (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
  .a_i(a_i), .b_i(b_i), .imm_i(imm_i), .use_imm_i(use_imm_i),
  .result_o(result_o), .flags_o(flags_o)
);

// File: tb/tb_inv_logic_alu.sv
`timescale 1ns/1ps
module tb_inv_logic_alu;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [4:0]  op_i = '0;
  logic [15:0] a_i = '0, b_i = '0;
  logic [7:0]  imm_i = '0;
  logic        use_imm_i = 1'b0;
  logic [15:0] result_o;
  logic [3:0]  flags_o;

  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;
  logic [3:0] exp_flags = '0;

  always #2.5 clk = ~clk;

  inv_logic_alu dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .imm_i(imm_i), .use_imm_i(use_imm_i),
    .result_o(result_o), .flags_o(flags_o)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [4:0] op);
    if (op <= 5'd1) return "R2";
    if (op <= 5'd3) return "R3";
    if (op <= 5'd9) return "R4";
    if (op == 5'd12 || op == 5'd13) return "R7";
    if (op <= 5'd15) return "R6";
    if (op == 5'd16) return "R8";
    if (op == 5'd17) return "R9";
    return "R11";
  endfunction

  // returns {C,V,N,Z,result}
  function automatic logic [19:0] model(input logic [4:0] op, input logic [15:0] a, input logic [15:0] b, input logic ci);
    int t, sv;
    logic [15:0] r;
    logic c, v;
    logic [31:0] rr;
    c = 0; v = 0; r = 0;
    case (op)
      0, 2: begin
        t  = int'(a) + int'(b) + ((op == 2) ? int'(ci) : 0);
        sv = int'($signed(a)) + int'($signed(b)) + ((op == 2) ? int'(ci) : 0);
        r = t[15:0]; c = t > 65535; v = sv > 32767 || sv < -32768;
      end
      1, 3: begin
        t  = int'(a) - int'(b) - ((op == 3) ? 1 - int'(ci) : 0);
        sv = int'($signed(a)) - int'($signed(b)) - ((op == 3) ? 1 - int'(ci) : 0);
        r = t[15:0]; c = t >= 0; v = sv > 32767 || sv < -32768;
      end
      4: r = a ^ b;   5: r = ~(a ^ b);
      6: r = a | b;   7: r = a | ~b;
      8: r = a & b;   9: r = a & ~b;
      10, 14: begin r = b << 1; c = b[15]; end
      11: begin r = b >> 1; c = b[0]; end
      15: begin r = 16'($signed(b) >>> 1); c = b[0]; end
      12: begin r = {b[14:0], ci}; c = b[15]; end
      13: begin r = {ci, b[15:1]}; c = b[0]; end
      16: begin rr = {a, a} << b[3:0]; r = rr[31:16]; end
      17: r = ~b;
      default: r = 0;
    endcase
    return {c, v, r[15], r == 0, r};
  endfunction

  task automatic apply(input logic [4:0] op, input logic [15:0] a, input logic [15:0] b,
                       input logic [7:0] imm, input logic ui, input logic v, output logic [15:0] got);
    logic [15:0] bb;
    logic [19:0] m;
    @(negedge clk);
    op_i = op; a_i = a; b_i = b; imm_i = imm; use_imm_i = ui; valid_i = v;
    #1;
    bb = ui ? {8'h00, imm} : b;
    m  = model(op, a, bb, exp_flags[3]);
    check(result_o == m[15:0], ui ? "R5" : req_of(op), 64'(result_o), 64'(m[15:0]));
    got = result_o;
    @(posedge clk); #1;
    if (v) exp_flags = m[19:16];
    check(flags_o == exp_flags, "R10", 64'(flags_o), 64'(exp_flags));
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog act=1 exp=0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] g, w0, w1, w2, w3;
    logic [63:0] x, y, s;
    void'($urandom(32'h5eed_0a1b));
    #12;
    check(flags_o == 4'b0000, "R1", 64'(flags_o), 64'h0);
    @(negedge clk); rst_ni = 1'b1;

    // R2 carry/zero, signed overflow, borrow
    apply(0, 16'hFFFF, 16'h0001, 0, 0, 1, g);
    check(flags_o == 4'b1001, "R2", 64'(flags_o), 64'h9);
    apply(0, 16'h7FFF, 16'h0001, 0, 0, 1, g);
    check(flags_o == 4'b0110, "R2", 64'(flags_o), 64'h6);
    apply(1, 16'h0005, 16'h0005, 0, 0, 1, g);
    check(flags_o == 4'b1001, "R2", 64'(flags_o), 64'h9);
    apply(1, 16'h0000, 16'h0001, 0, 0, 1, g);
    check(g == 16'hFFFF && flags_o == 4'b0010, "R2", {g, 44'(flags_o)}, {16'hFFFF, 44'h2});
    // R12 codes: SUBC with C=0 subtracts one extra
    apply(3, 16'h0010, 16'h0001, 0, 0, 1, g);
    check(g == 16'h000E, "R12", 64'(g), 64'hE);

    // R3 32-bit and 64-bit chains
    x = 64'h0000_0000_89AB_FFFF; y = 64'h0000_0000_1234_0001;
    apply(0, x[15:0],  y[15:0],  0, 0, 1, w0);
    apply(2, x[31:16], y[31:16], 0, 0, 1, w1);
    s = x + y;
    check({w1, w0} == s[31:0], "R3", 64'({w1, w0}), 64'(s[31:0]));
    x = 64'hFFFF_0123_FFFF_8000; y = 64'h0001_FEDC_0000_8000;
    apply(0, x[15:0],  y[15:0],  0, 0, 1, w0);
    apply(2, x[31:16], y[31:16], 0, 0, 1, w1);
    apply(2, x[47:32], y[47:32], 0, 0, 1, w2);
    apply(2, x[63:48], y[63:48], 0, 0, 1, w3);
    s = x + y;
    check({w3, w2, w1, w0} == s, "R3", {w3, w2, w1, w0}, s);

    // R4 inverted forms
    apply(7, 16'h0F00, 16'hFFF0, 0, 0, 1, g);
    check(g == 16'h0F0F, "R4", 64'(g), 64'h0F0F);
    apply(9, 16'hFFFF, 16'h00FF, 0, 0, 1, g);
    check(g == 16'hFF00, "R4", 64'(g), 64'hFF00);
    apply(5, 16'h1234, 16'h1234, 0, 0, 1, g);
    check(g == 16'hFFFF, "R4", 64'(g), 64'hFFFF);

    // R5 immediate ignores b_i
    apply(6, 16'h1200, 16'hFFFF, 8'h34, 1, 1, g);
    check(g == 16'h1234, "R5", 64'(g), 64'h1234);

    // R7 rotate through carry with C set then cleared
    apply(0, 16'hFFFF, 16'h0001, 0, 0, 1, g);
    apply(12, 16'h0, 16'h4000, 0, 0, 1, g);
    check(g == 16'h8001, "R7", 64'(g), 64'h8001);
    apply(13, 16'h0, 16'h0002, 0, 0, 1, g);
    check(g == 16'h0001, "R7", 64'(g), 64'h1);

    // R6 ASHR keeps msb
    apply(15, 16'h0, 16'h8003, 0, 0, 1, g);
    check(g == 16'hC001 && flags_o[3], "R6", 64'(g), 64'hC001);

    // R8 amount uses low bits only
    apply(16, 16'h8001, 16'hFFF0, 0, 0, 1, g);
    check(g == 16'h8001, "R8", 64'(g), 64'h8001);
    apply(16, 16'h8001, 16'h000F, 0, 0, 1, g);
    check(g == 16'hC000, "R8", 64'(g), 64'hC000);

    // R9, R11
    apply(17, 16'h0, 16'hA5A5, 0, 0, 1, g);
    check(g == 16'h5A5A, "R9", 64'(g), 64'h5A5A);
    apply(0, 16'hFFFF, 16'h0001, 0, 0, 1, g);
    apply(25, 16'hFFFF, 16'hFFFF, 0, 0, 1, g);
    check(flags_o == 4'b0001, "R11", 64'(flags_o), 64'h1);

    // R10 hold while not valid
    apply(0, 16'h8000, 16'h8000, 0, 0, 0, g);
    check(flags_o == 4'b0001, "R10", 64'(flags_o), 64'h1);

    for (int i = 0; i < 3000; i++) begin
      apply(5'($urandom_range(0, 19)), 16'($urandom), 16'($urandom), 8'($urandom),
            ($urandom_range(0, 3) == 0), ($urandom_range(0, 7) != 0), g);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule